// File: doc/BRIEF.md
# Odd-Even 50% Duty Clock Divider

This block takes a fast oscillator clock and produces a slower clock for a downstream output stage. The division ratio is any integer from 1 to 6. The output keeps an exact 50% duty cycle at every ratio, odd ones included. For odd ratios the high time of N/2 input cycles ends on a falling input edge, so part of the logic works on the falling edge.

The ratio comes from a 3-bit code whose binary value is the ratio itself. Codes outside the legal range silence the output and raise a sticky error flag. A new code is taken only when the current output period ends, so no short pulse ever reaches the output stage. Two independent mute sources hold the output low: a register-style bit that is active high, and an external pin that is active low. While muted, the dividing counters keep running, so the output comes back in its old phase when the mute is released. Reset is synchronous and active low.

Top module: `odd_even_clkdiv`

## Requirements
- R1: With a legal code N (ratio_i binary value 1..6), the output period is exactly N input clock cycles.
- R2: For N from 2 to 6 the output high time is N/2 input cycles: N/2 full cycles for even N, and (N-1)/2 cycles plus one half cycle for odd N. Each output period starts on a rising input edge.
- R3: Code 1 passes the input clock straight to the output, so the high time is one half cycle and the period is one cycle.
- R4: Codes 0 and 7 hold clk_o low. err_o goes to 1 on the input clock edge that accepts such a code.
- R5: err_o stays at 1 until a legal code is accepted. While an illegal code is active, a legal code is accepted on the next rising input edge, and err_o drops on that edge.
- R6: A code change, legal or illegal, takes effect only at the end of the current output period. No high or low phase has a length other than the one set by the old ratio or the new ratio.
- R7: While mute_reg_i is 1, clk_o is held low.
- R8: While mute_n_i is 0, clk_o is held low. Either mute source alone is enough.
- R9: The dividing counters keep running while the output is muted. After unmute, the next output rising edge falls a whole number of output periods after the rising edges from before the mute.
- R10: While rst_n_i is 0 at a rising input edge, clk_o is low and err_o is 0. The first rising edge after reset is released accepts ratio_i and, for a legal ratio of 2 or more, begins a high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_n_i | input | 1 | Synchronous reset, active low |
| ratio_i | input | 3 | Division ratio code; its binary value is the ratio |
| mute_reg_i | input | 1 | Register mute bit; 1 silences the output |
| mute_n_i | input | 1 | External mute pin; 0 silences the output |
| clk_o | output | 1 | Divided clock with 50% duty |
| err_o | output | 1 | Sticky flag: an illegal ratio code is active |

## Verification
For each ratio, the bench samples the output twice per input cycle and measures the period and the high time in half-cycle units. A design without the falling-edge stretch would show a high time one half cycle short at ratios 3 and 5. A design that took a new code at once would produce a low phase that is neither 6 nor 2 half cycles long when the ratio moves from 6 to 2 in mid-period. An illegal code written just after an output rising edge must leave the output high and err_o clear until the period ends. The last test mutes for an odd number of half cycles and checks that the output returns in its old phase; a design that restarted its counters on unmute would lose that phase.

// File: rtl/odd_even_clkdiv_pkg.sv
package odd_even_clkdiv_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE   = 2'd0,
      MODE_BYPASS = 2'd1,
      MODE_EVEN   = 2'd2,
      MODE_ODD    = 2'd3
   } div_mode_e;

   function automatic bit ratio_ok(input int code, input int lo, input int hi);
      return (code >= lo) && (code <= hi);
   endfunction

   // whole input cycles of the rising-edge high pulse
   function automatic int rise_high(input int n);
      return n / 2;
   endfunction

endpackage

// File: rtl/odd_even_clkdiv_ctrl.sv
module odd_even_clkdiv_ctrl
   import odd_even_clkdiv_pkg::*;
#(
   parameter int RATIO_W   = 3,
   parameter int MIN_RATIO = 1,
   parameter int MAX_RATIO = 6,
   parameter int CNT_W     = 3
) (
   input  logic               clk_i,
   input  logic               rst_n_i,
   input  logic [RATIO_W-1:0] ratio_i,
   output logic [CNT_W-1:0]   cnt_o,
   output logic [RATIO_W-1:0] act_o,
   output logic               load_o,
   output logic               pos_o,
   output logic               err_o,
   output div_mode_e          mode_o
);

   logic [RATIO_W-1:0] act_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   cnt_d;
   logic               pos_q;
   logic               err_q;
   logic               act_ok;
   logic               in_ok;
   logic               at_end;

   always_comb begin
      act_ok = ratio_ok(int'(act_q), MIN_RATIO, MAX_RATIO);
      in_ok  = ratio_ok(int'(ratio_i), MIN_RATIO, MAX_RATIO);
      at_end = (int'(cnt_q) + 1) == int'(act_q);
      load_o = !act_ok || at_end;
      cnt_d  = load_o ? '0 : cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         act_q <= '0;
         cnt_q <= '0;
         pos_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         if (load_o) begin
            act_q <= ratio_i;
            err_q <= !in_ok;
            pos_q <= in_ok && (rise_high(int'(ratio_i)) != 0);
         end else begin
            pos_q <= int'(cnt_d) < rise_high(int'(act_q));
         end
      end
   end

   always_comb begin
      if (!act_ok)                       mode_o = MODE_IDLE;
      else if (act_q == RATIO_W'(1))     mode_o = MODE_BYPASS;
      else if (act_q[0])                 mode_o = MODE_ODD;
      else                               mode_o = MODE_EVEN;
   end

   assign cnt_o = cnt_q;
   assign act_o = act_q;
   assign pos_o = pos_q;
   assign err_o = err_q;

endmodule

// File: rtl/odd_even_clkdiv_shape.sv
module odd_even_clkdiv_shape
   import odd_even_clkdiv_pkg::*;
#(
   parameter bit EXACT_ODD = 1'b1
) (
   input  logic      clk_i,
   input  logic      rst_n_i,
   input  logic      pos_i,
   input  div_mode_e mode_i,
   output logic      shaped_o
);

   logic ext;

   generate
      if (EXACT_ODD) begin : g_dual_edge
         logic neg_q;
         always_ff @(negedge clk_i) begin
            if (!rst_n_i) neg_q <= 1'b0;
            else          neg_q <= pos_i;
         end
         assign ext = neg_q;
      end else begin : g_single_edge
         assign ext = 1'b0;
      end
   endgenerate

   always_comb begin
      case (mode_i)
         MODE_EVEN: shaped_o = pos_i;
         MODE_ODD:  shaped_o = pos_i | ext;
         default:   shaped_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/odd_even_clkdiv_gate.sv
module odd_even_clkdiv_gate
   import odd_even_clkdiv_pkg::*;
(
   input  logic      clk_i,
   input  div_mode_e mode_i,
   input  logic      shaped_i,
   input  logic      mute_reg_i,
   input  logic      mute_n_i,
   output logic      clk_o
);

   logic quiet;
   logic raw;

   always_comb begin
      quiet = mute_reg_i || !mute_n_i;
      raw   = (mode_i == MODE_BYPASS) ? clk_i : shaped_i;
      clk_o = raw && !quiet;
   end

endmodule

// File: rtl/odd_even_clkdiv.sv
module odd_even_clkdiv
   import odd_even_clkdiv_pkg::*;
#(
   parameter int RATIO_W   = 3,
   parameter int MIN_RATIO = 1,
   parameter int MAX_RATIO = 6,
   parameter bit EXACT_ODD = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_n_i,
   input  logic [RATIO_W-1:0] ratio_i,
   input  logic               mute_reg_i,
   input  logic               mute_n_i,
   output logic               clk_o,
   output logic               err_o
);

   localparam int CNT_W = (MAX_RATIO > 1) ? $clog2(MAX_RATIO) : 1;

   generate
      if (MIN_RATIO < 1 || MAX_RATIO < MIN_RATIO || MAX_RATIO >= (1 << RATIO_W)) begin : g_bad_range
         $error("odd_even_clkdiv: ratio range does not fit the code width");
      end
   endgenerate

   logic [CNT_W-1:0]   cnt_w;
   logic [RATIO_W-1:0] act_w;
   logic               load_w;
   logic               pos_w;
   logic               shaped_w;
   div_mode_e          mode_w;

   odd_even_clkdiv_ctrl #(
      .RATIO_W  (RATIO_W),
      .MIN_RATIO(MIN_RATIO),
      .MAX_RATIO(MAX_RATIO),
      .CNT_W    (CNT_W)
   ) u_ctrl (
      .clk_i  (clk_i),
      .rst_n_i(rst_n_i),
      .ratio_i(ratio_i),
      .cnt_o  (cnt_w),
      .act_o  (act_w),
      .load_o (load_w),
      .pos_o  (pos_w),
      .err_o  (err_o),
      .mode_o (mode_w)
   );

   odd_even_clkdiv_shape #(
      .EXACT_ODD(EXACT_ODD)
   ) u_shape (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .pos_i   (pos_w),
      .mode_i  (mode_w),
      .shaped_o(shaped_w)
   );

   odd_even_clkdiv_gate u_gate (
      .clk_i     (clk_i),
      .mode_i    (mode_w),
      .shaped_i  (shaped_w),
      .mute_reg_i(mute_reg_i),
      .mute_n_i  (mute_n_i),
      .clk_o     (clk_o)
   );

endmodule

// File: rtl/odd_even_clkdiv_chk.sv
module odd_even_clkdiv_chk #(
   parameter int RATIO_W   = 3,
   parameter int MIN_RATIO = 1,
   parameter int MAX_RATIO = 6,
   parameter int CNT_W     = 3
) (
   input logic               clk_i,
   input logic               rst_n_i,
   input logic [RATIO_W-1:0] ratio_i,
   input logic               mute_reg_i,
   input logic               mute_n_i,
   input logic               clk_o,
   input logic               err_o,
   input logic               load_i,
   input logic [RATIO_W-1:0] act_i,
   input logic [CNT_W-1:0]   cnt_i
);

   logic in_legal;
   logic act_legal;

   assign in_legal  = (int'(ratio_i) >= MIN_RATIO) && (int'(ratio_i) <= MAX_RATIO);
   assign act_legal = (int'(act_i) >= MIN_RATIO) && (int'(act_i) <= MAX_RATIO);

   // R7
   reg_mute_low_chk: assert property (@(negedge clk_i) disable iff (!rst_n_i)
      mute_reg_i |-> !clk_o);

   // R8
   pin_mute_low_chk: assert property (@(negedge clk_i) disable iff (!rst_n_i)
      !mute_n_i |-> !clk_o);

   // R4
   bad_code_quiet_chk: assert property (@(negedge clk_i) disable iff (!rst_n_i)
      err_o |-> !clk_o);

   // R4
   bad_code_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (load_i && !in_legal) |=> err_o);

   // R5
   good_code_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (load_i && in_legal) |=> !err_o);

   // R6
   ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !load_i |=> $stable(act_i));

   // R1
   count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      act_legal |-> (int'(cnt_i) < int'(act_i)));

endmodule

bind odd_even_clkdiv odd_even_clkdiv_chk #(
   .RATIO_W  (RATIO_W),
   .MIN_RATIO(MIN_RATIO),
   .MAX_RATIO(MAX_RATIO),
   .CNT_W    (CNT_W)
) u_chk (
   .clk_i     (clk_i),
   .rst_n_i   (rst_n_i),
   .ratio_i   (ratio_i),
   .mute_reg_i(mute_reg_i),
   .mute_n_i  (mute_n_i),
   .clk_o     (clk_o),
   .err_o     (err_o),
   .load_i    (load_w),
   .act_i     (act_w),
   .cnt_i     (cnt_w)
);

// File: tb/odd_even_clkdiv_test.sv
`timescale 1ns/1ps
module odd_even_clkdiv_test;

   logic       clk   = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] ratio = 3'd2;
   logic       mreg  = 1'b0;
   logic       mn    = 1'b1;
   logic       clk_o;
   logic       err_o;

   int nchk = 0;
   int nbad = 0;
   int gidx = 0;
   bit done = 1'b0;
   bit buf_s [64];

   typedef struct packed {
      logic [2:0] code;
      logic       mreg;
      logic       mn;
      logic [7:0] hi;    // expected high time in half cycles, 0 = silent
      logic [7:0] per;   // expected period in half cycles
      logic       err;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{3'd1, 1'b0, 1'b1, 8'd1, 8'd2,  1'b0},
      '{3'd2, 1'b0, 1'b1, 8'd2, 8'd4,  1'b0},
      '{3'd3, 1'b0, 1'b1, 8'd3, 8'd6,  1'b0},
      '{3'd4, 1'b0, 1'b1, 8'd4, 8'd8,  1'b0},
      '{3'd5, 1'b0, 1'b1, 8'd5, 8'd10, 1'b0},
      '{3'd6, 1'b0, 1'b1, 8'd6, 8'd12, 1'b0},
      '{3'd3, 1'b1, 1'b1, 8'd0, 8'd0,  1'b0},
      '{3'd5, 1'b0, 1'b0, 8'd0, 8'd0,  1'b0},
      '{3'd0, 1'b0, 1'b1, 8'd0, 8'd0,  1'b1},
      '{3'd7, 1'b0, 1'b1, 8'd0, 8'd0,  1'b1},
      '{3'd2, 1'b1, 1'b0, 8'd0, 8'd0,  1'b0}
   };

   always #2.5 clk = ~clk;

   odd_even_clkdiv uut (
      .clk_i     (clk),
      .rst_n_i   (rst_n),
      .ratio_i   (ratio),
      .mute_reg_i(mreg),
      .mute_n_i  (mn),
      .clk_o     (clk_o),
      .err_o     (err_o)
   );

   task automatic chk(input bit ok, input string req, input int actv, input int expv);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
      end
   endtask

   task automatic half();
      #2.5;
      gidx++;
   endtask

   task automatic grab(input int n);
      for (int i = 0; i < n; i++) begin
         half();
         buf_s[i] = clk_o;
      end
   endtask

   task automatic count_ones(input int n, output int ones);
      ones = 0;
      for (int i = 0; i < n; i++) begin
         half();
         if (clk_o) ones++;
      end
   endtask

   task automatic wait_rise(output int idx, input int lim);
      bit prev;
      prev = clk_o;
      idx  = -1;
      for (int i = 0; i < lim; i++) begin
         half();
         if (!prev && clk_o) begin
            idx = gidx;
            return;
         end
         prev = clk_o;
      end
   endtask

   task automatic measure(input int n, output int ones, output int hi, output int per);
      int r0, f0, r1;
      r0 = -1; f0 = -1; r1 = -1; ones = 0;
      grab(n);
      for (int i = 0; i < n; i++) if (buf_s[i]) ones++;
      for (int i = 1; i < n; i++) if (r0 < 0 && !buf_s[i-1] && buf_s[i]) r0 = i;
      if (r0 >= 0) for (int i = r0 + 1; i < n; i++) if (f0 < 0 && !buf_s[i]) f0 = i;
      if (f0 >= 0) for (int i = f0 + 1; i < n; i++) if (r1 < 0 && !buf_s[i-1] && buf_s[i]) r1 = i;
      hi  = (f0 >= 0) ? f0 - r0 : -1;
      per = (r1 >= 0) ? r1 - r0 : -1;
   endtask

   initial begin
      #100000;
      if (!done) begin
         nbad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      int ones, hi, per, ra, rb;
      #3.75;   // now 1.25 ns after a rising edge

      // R10: quiet during reset
      count_ones(20, ones);
      chk(ones == 0, "R10 clk_o low in reset", ones, 0);
      chk(err_o == 1'b0, "R10 err_o clear in reset", int'(err_o), 0);
      rst_n = 1'b1;
      half(); half();
      chk(clk_o == 1'b1, "R10 first edge starts high phase", int'(clk_o), 1);
      half();
      chk(clk_o == 1'b1, "R10 high phase second half", int'(clk_o), 1);
      half();
      chk(clk_o == 1'b0, "R10 low after one cycle at ratio 2", int'(clk_o), 0);

      // table of ratios and mute cases
      for (int v = 0; v < NV; v++) begin
         ratio = VECS[v].code;
         mreg  = VECS[v].mreg;
         mn    = VECS[v].mn;
         repeat (30) half();
         measure(48, ones, hi, per);
         if (VECS[v].per == 8'd0) begin
            if (VECS[v].mreg)     chk(ones == 0, "R7 register mute silent", ones, 0);
            else if (!VECS[v].mn) chk(ones == 0, "R8 pin mute silent", ones, 0);
            else                  chk(ones == 0, "R4 illegal code silent", ones, 0);
         end else begin
            chk(per == int'(VECS[v].per), "R1 period in half cycles", per, int'(VECS[v].per));
            if (VECS[v].code == 3'd1)
               chk(hi == int'(VECS[v].hi), "R3 bypass high time", hi, int'(VECS[v].hi));
            else
               chk(hi == int'(VECS[v].hi), "R2 high time in half cycles", hi, int'(VECS[v].hi));
         end
         chk(err_o == VECS[v].err, "R4 error flag per code", int'(err_o), int'(VECS[v].err));
      end
      mreg = 1'b0;
      mn   = 1'b1;

      // R5: sticky error, cleared by the next edge after a legal code
      ratio = 3'd0;
      repeat (6) half();
      chk(err_o == 1'b1, "R4 flag raised by code 0", int'(err_o), 1);
      ratio = 3'd3;
      half();
      chk(err_o == 1'b1, "R5 flag held until a clock edge", int'(err_o), 1);
      half();
      chk(err_o == 1'b0, "R5 flag cleared by legal code", int'(err_o), 0);

      // R6: illegal code written mid-period waits for the period end
      ratio = 3'd6;
      repeat (30) half();
      wait_rise(ra, 40);
      chk(ra >= 0, "R6 rise found at ratio 6", ra, 0);
      ratio = 3'd7;
      repeat (4) half();
      chk(err_o == 1'b0, "R6 illegal code not yet taken", int'(err_o), 0);
      chk(clk_o == 1'b1, "R6 high phase continues", int'(clk_o), 1);
      repeat (12) half();
      chk(err_o == 1'b1, "R6 illegal code taken at period end", int'(err_o), 1);

      // R6: ratio 6 to 2 inside the low phase, no runt
      ratio = 3'd6;
      repeat (30) half();
      wait_rise(ra, 40);
      begin
         int len, nruns, n2, badlen;
         for (int i = 0; i < 64; i++) begin
            half();
            buf_s[i] = clk_o;
            if (i == 7) ratio = 3'd2;
         end
         len = 1; nruns = 0; n2 = 0; badlen = -1;
         for (int i = 1; i < 64; i++) begin
            if (buf_s[i] == buf_s[i-1]) len++;
            else begin
               if (nruns > 0) begin
                  if (len != 2 && len != 6) badlen = len;
                  if (len == 2) n2++;
               end
               nruns++;
               len = 1;
            end
         end
         chk(badlen == -1, "R6 no runt phase on ratio change", badlen, -1);
         chk(n2 >= 4, "R6 new ratio in effect", n2, 4);
      end

      // R9: counters run on while muted
      ratio = 3'd4;
      repeat (20) half();
      wait_rise(ra, 40);
      mreg = 1'b1;
      count_ones(21, ones);
      chk(ones == 0, "R7 mute holds output low", ones, 0);
      mreg = 1'b0;
      wait_rise(rb, 40);
      chk(rb > 0 && ((rb - ra) % 8) == 0, "R9 phase kept across mute", (rb - ra) % 8, 0);

      // R10: reset in mid-run clears flag and output
      ratio = 3'd7;
      repeat (10) half();
      chk(err_o == 1'b1, "R4 flag raised by code 7", int'(err_o), 1);
      rst_n = 1'b0;
      repeat (4) half();
      chk(err_o == 1'b0, "R10 reset clears flag", int'(err_o), 0);
      count_ones(16, ones);
      chk(ones == 0, "R10 reset holds output low", ones, 0);
      rst_n = 1'b1;
      ratio = 3'd2;
      repeat (4) half();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

endmodule